// File: doc/BRIEF.md
# Multiplexed DRAM Address Controller

This block sits between a requester holding a flat 16-bit byte address and a DRAM whose 256-by-256 cell array is reached through an 8-bit shared address bus. The upper address byte selects the row and the lower byte selects the column. The block sends the two halves over the narrow bus one after the other and marks each with its own active-low strobe. It drives the write-enable and data lines for writes and captures read data at the end of the column phase.

The block also keeps a page open. After an access the row strobe stays low. A later access to the same row issues only a new column strobe, which makes it much shorter. An access to a different row first raises the row strobe for a precharge period. If the requester stays idle for a set number of cycles, the block closes the open page. The setup, row-to-column, column access, precharge and idle-close intervals are parameters counted in clock cycles.

The requester holds `req_valid` and its fields until `req_ready` pulses. That pulse marks a finished write or valid read data on `rsp_rdata`.

Top module: `mux_dram_ctrl`

## Requirements
- R1: The row strobe latches `req_addr[15:8]` from `dram_addr`, and the column strobe latches `req_addr[7:0]`.
- R2: The column strobe goes low only while the row strobe is already low and was low in the cycle before, so both strobes are never low without a prior row phase.
- R3: After reset both strobes are high, `req_ready` is low and `dram_dq_oe` is low.
- R4: With no page open, `req_ready` rises ROW_SETUP+ROW_TO_COL+COL_ACCESS cycles (default 7) after the edge that accepts the request.
- R5: An access to the row that is already open issues no new row strobe, and `req_ready` rises COL_ACCESS cycles (default 2) after acceptance.
- R6: An access to a different row raises the row strobe for at least PRECHARGE cycles (default 2, never fewer than 2) before the new row phase. Its latency is PRECHARGE+ROW_SETUP+ROW_TO_COL+COL_ACCESS (default 9).
- R7: `req_ready` is high for exactly one cycle. For a read, `rsp_rdata` holds the word that the DRAM returned in that cycle.
- R8: During a write column phase `dram_we_n` is 0, `dram_dq_oe` is 1 and `dram_dq_out` equals the write data. During a read column phase `dram_we_n` is 1 and `dram_dq_oe` is 0.
- R9: After IDLE_CLOSE idle cycles (default 8) with a page open, the row strobe returns high. The next access, even to the same row, then takes the full R4 latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present, held until `req_ready` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Flat address, row in [15:8], column in [7:0] |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read data, valid with `req_ready` |
| dram_addr | output | 8 | Shared row/column address bus |
| dram_row_n | output | 1 | Active-low row strobe |
| dram_col_n | output | 1 | Active-low column strobe |
| dram_we_n | output | 1 | Active-low write enable |
| dram_dq_out | output | 8 | Data driven toward the DRAM |
| dram_dq_oe | output | 1 | Data output enable |
| dram_dq_in | input | 8 | Data returned by the DRAM |

## Verification
Suppose the block holds a wrong open-row record. A same-row access would then skip the row phase toward the wrong row, or a different-row access would skip precharge. Either fault shows within one access, as a wrong `req_ready` latency or a wrong row seen by the array model. A miscounted phase moves the ready pulse by at least one cycle on the very next request. A strobe-ordering slip shows in the first cycle the column strobe falls. A broken idle counter shows as a row strobe still low after the idle window, or as a short latency on the access that follows.

// File: rtl/mux_dram_ctrl.sv
`timescale 1ns/1ps
module mux_dram_ctrl #(
  parameter int AW         = 16,
  parameter int DW         = 8,
  parameter int ROW_SETUP  = 2,
  parameter int ROW_TO_COL = 3,
  parameter int COL_ACCESS = 2,
  parameter int PRECHARGE  = 2,
  parameter int IDLE_CLOSE = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW/2-1:0] dram_addr,
  output logic          dram_row_n,
  output logic          dram_col_n,
  output logic          dram_we_n,
  output logic [DW-1:0] dram_dq_out,
  output logic          dram_dq_oe,
  input  logic [DW-1:0] dram_dq_in
);
  localparam int HW  = AW / 2;
  localparam int M1  = (ROW_SETUP > ROW_TO_COL) ? ROW_SETUP : ROW_TO_COL;
  localparam int M2  = (COL_ACCESS > PRECHARGE) ? COL_ACCESS : PRECHARGE;
  localparam int M3  = (M1 > M2) ? M1 : M2;
  localparam int MX  = (M3 > IDLE_CLOSE) ? M3 : IDLE_CLOSE;
  localparam int CW  = $clog2(MX + 1);

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_RSET, S_RCD, S_COL} st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic          page_open, pend;
  logic [HW-1:0] open_row;
  logic [AW-1:0] cur_addr;
  logic          cur_wr;
  logic [DW-1:0] cur_wd;

  wire row_hit = page_open && (req_addr[AW-1:HW] == open_row);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      page_open <= 1'b0;
      pend      <= 1'b0;
      open_row  <= '0;
      cur_addr  <= '0;
      cur_wr    <= 1'b0;
      cur_wd    <= '0;
      req_ready <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      req_ready <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req_valid && !req_ready) begin
            cur_addr <= req_addr;
            cur_wr   <= req_write;
            cur_wd   <= req_wdata;
            cnt      <= '0;
            if (row_hit) state <= S_COL;
            else if (page_open) begin
              state     <= S_PRE;
              page_open <= 1'b0;
              pend      <= 1'b1;
            end else state <= S_RSET;
          end else if (page_open) begin
            if (cnt == CW'(IDLE_CLOSE - 1)) begin
              state     <= S_PRE;
              page_open <= 1'b0;
              pend      <= 1'b0;
              cnt       <= '0;
            end else cnt <= cnt + 1'b1;
          end
        end
        S_PRE: begin
          if (cnt == CW'(PRECHARGE - 1)) begin
            cnt   <= '0;
            state <= pend ? S_RSET : S_IDLE;
            pend  <= 1'b0;
          end else cnt <= cnt + 1'b1;
        end
        S_RSET: begin
          if (cnt == CW'(ROW_SETUP - 1)) begin
            cnt   <= '0;
            state <= S_RCD;
          end else cnt <= cnt + 1'b1;
        end
        S_RCD: begin
          if (cnt == CW'(ROW_TO_COL - 1)) begin
            cnt       <= '0;
            state     <= S_COL;
            page_open <= 1'b1;
            open_row  <= cur_addr[AW-1:HW];
          end else cnt <= cnt + 1'b1;
        end
        S_COL: begin
          if (cnt == CW'(COL_ACCESS - 1)) begin
            cnt       <= '0;
            state     <= S_IDLE;
            req_ready <= 1'b1;
            if (!cur_wr) rsp_rdata <= dram_dq_in;
          end else cnt <= cnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign dram_row_n  = !(state == S_RCD || state == S_COL || (state == S_IDLE && page_open));
  assign dram_col_n  = !(state == S_COL);
  assign dram_addr   = (state == S_COL) ? cur_addr[HW-1:0] :
                       (state == S_IDLE) ? open_row : cur_addr[AW-1:HW];
  assign dram_dq_oe  = (state == S_COL) && cur_wr;
  assign dram_we_n   = !dram_dq_oe;
  assign dram_dq_out = cur_wd;

  p_col_needs_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_col_n |-> !dram_row_n);
  p_col_fall_after_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_col_n) |-> $past(!dram_row_n));
  p_precharge_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_row_n) |=> dram_row_n);
  p_ready_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);
  p_col_addr_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_col_n && $past(!dram_col_n)) |-> $stable(dram_addr));
  p_we_in_col_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_we_n |-> !dram_col_n);
endmodule

// File: tb/mux_dram_ctrl_test.sv
`timescale 1ns/1ps
module mux_dram_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, dram_row_n, dram_col_n, dram_we_n, dram_dq_oe;
  logic [7:0] rsp_rdata, dram_addr, dram_dq_out, dram_dq_in;

  always #5 clk = ~clk;

  mux_dram_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_rdata(rsp_rdata), .dram_addr(dram_addr), .dram_row_n(dram_row_n),
    .dram_col_n(dram_col_n), .dram_we_n(dram_we_n), .dram_dq_out(dram_dq_out),
    .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in));

  // behavioural array model, cells indexed by low nibbles of row and column
  logic [7:0] mem [256];
  logic [7:0] row_l = '0, col_l = '0;
  logic prow = 1'b1, pcol = 1'b1;
  int acts = 0, illegal = 0, dir_bad = 0;
  assign dram_dq_in = mem[{row_l[3:0], dram_addr[3:0]}];

  always @(posedge clk) begin
    prow <= dram_row_n;
    pcol <= dram_col_n;
    if (rst_n) begin
      if (!dram_row_n && prow) begin row_l <= dram_addr; acts <= acts + 1; end
      if (!dram_col_n && dram_row_n) illegal <= illegal + 1;
      if (!dram_col_n && pcol) begin
        col_l <= dram_addr;
        if (!dram_we_n) begin
          if (!dram_dq_oe) dir_bad <= dir_bad + 1;
          mem[{row_l[3:0], dram_addr[3:0]}] <= dram_dq_out;
        end else if (dram_dq_oe) dir_bad <= dir_bad + 1;
      end
    end
  end

  int checks = 0, failures = 0;
  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [15:0] a, input logic [7:0] d,
                        output int n, output logic [7:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    n = 0;
    do begin @(negedge clk); n++; end while (!req_ready && n < 100);
    rd = rsp_rdata;
    req_valid = 1'b0;
    @(negedge clk);
    check(!req_ready, "R7 ready width", int'(req_ready), 0);
  endtask

  // {write, addr, data, edges from drive to ready seen}
  localparam logic [32:0] VEC [7] = '{
    {1'b1, 16'h1203, 8'hA5, 8'd8},
    {1'b1, 16'h1207, 8'h5A, 8'd3},
    {1'b0, 16'h1203, 8'hA5, 8'd3},
    {1'b1, 16'h3403, 8'hC3, 8'd10},
    {1'b0, 16'h1207, 8'h5A, 8'd10},
    {1'b0, 16'h1203, 8'hA5, 8'd3},
    {1'b0, 16'h3403, 8'hC3, 8'd10}
  };

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n, a0;
    logic [7:0] rd;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(dram_row_n && dram_col_n, "R3 strobes high", {dram_row_n, dram_col_n}, 3);
    check(!req_ready && !dram_dq_oe, "R3 ready/oe low", {req_ready, dram_dq_oe}, 0);

    for (int v = 0; v < 7; v++) begin
      a0 = acts;
      access(VEC[v][32], VEC[v][31:16], VEC[v][15:8], n, rd);
      check(n == int'(VEC[v][7:0]), "R4/R5/R6 latency", n, int'(VEC[v][7:0]));
      check(row_l == VEC[v][31:24] && col_l == VEC[v][23:16], "R1 row/col split",
            {row_l, col_l}, int'(VEC[v][31:16]));
      if (VEC[v][7:0] == 8'd3)
        check(acts == a0, "R5 no new row strobe", acts - a0, 0);
      else
        check(acts == a0 + 1, "R6 one row strobe", acts - a0, 1);
      if (!VEC[v][32])
        check(rd == VEC[v][15:8], "R7 read data", int'(rd), int'(VEC[v][15:8]));
    end
    check(illegal == 0, "R2 column without row", illegal, 0);
    check(dir_bad == 0, "R8 we/oe in column phase", dir_bad, 0);

    repeat (5) @(negedge clk);
    check(!dram_row_n, "R9 page still open before limit", int'(dram_row_n), 0);
    repeat (8) @(negedge clk);
    check(dram_row_n, "R9 page closed after idle", int'(dram_row_n), 1);
    a0 = acts;
    access(1'b0, 16'h3403, 8'h00, n, rd);
    check(n == 8, "R9 full latency after close", n, 8);
    check(acts == a0 + 1, "R9 new row strobe", acts - a0, 1);
    check(rd == 8'hC3, "R7 read after reopen", int'(rd), 8'hC3);

    access(1'b1, 16'h3409, 8'h3C, n, rd);
    check(n == 3, "R5 hit write", n, 3);
    access(1'b0, 16'h3409, 8'h00, n, rd);
    check(rd == 8'h3C && n == 3, "R8 write landed", int'(rd), 8'h3C);
    check(illegal == 0 && dir_bad == 0, "R2 R8 final", illegal + dir_bad, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule